// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous master for an asynchronous static RAM array of 64K words by 40 bits. The array is built from three 16-bit devices that share one set of strobes. A client raises a request with a write flag, a word address and write data. The controller then runs one bus cycle on the array. Each cycle is made of phases, and each phase lasts a parameterised number of clock cycles. This keeps every minimum pulse, setup, hold and recovery time of the memory without any analogue timing.

A read presents the address, waits out the setup phase, and then lowers the chip and output enables for the access time. It captures the bus on the last clock of that phase. A write presents the address, lowers chip and write enable together for the pulse width, and keeps output enable high. It drives the data bus from the strobe fall until the end of a hold phase. After a write, a recovery gap must pass before the next cycle may start. The 40-bit word is spread over the three 16-bit lanes. The top 8 bits of the last lane are written as zero and discarded on read.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, ce_n_o, we_n_o and oe_n_o are high, dq_oe_o is low, and busy_o and done_o are low.
- R2: A read holds we_n_o high and ce_n_o and oe_n_o low for exactly T_RD cycles. rdata_o is the bus value captured on the last of those cycles.
- R3: A write holds ce_n_o and we_n_o low together for exactly T_WP cycles. oe_n_o stays high whenever we_n_o is low.
- R4: addr_o carries the request address for T_AS cycles before any strobe falls. It stays unchanged while ce_n_o is low.
- R5: dq_oe_o is high from the cycle the write strobes fall through T_DH cycles after they rise, and low at all other times. It is never high while oe_n_o is low.
- R6: After a write, busy_o stays high for T_WR cycles, counting from the cycle in which done_o is high. No request is accepted until busy_o is low.
- R7: A request raised while busy_o is high has no effect. It starts no bus cycle and changes no stored word.
- R8: Bus lane d carries word bits [16d+15:16d]. On write, bus bits 47:40 are driven zero. On read, bus bits 47:40 are ignored.
- R9: done_o is a one-cycle pulse after each completed cycle. After a read, busy_o is already low in that cycle, so a new request raised then is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle when not busy |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 40 | Write data |
| rdata_o | output | 40 | Captured read word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Cycle in progress or recovery pending |
| addr_o | output | 16 | Address to the memory array |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| dq_o | output | 48 | Data driven onto the shared bus |
| dq_oe_o | output | 1 | Bus driver enable (tri-state control) |
| dq_i | input | 48 | Data read from the shared bus |

## Verification
The bench's memory model returns a poison pattern until the read strobes have been low for the full access count. A controller that captured one clock early would therefore return wrong data instead of the stored word. A request held high during a write, aimed at an address already written, would overwrite that word if the busy gate leaked. The stored word is read back afterwards to detect this. The recovery gap is measured after each write, and busy is checked to be low in the done cycle of each read. A controller that skipped recovery would start its next cycle early. One that applied recovery after reads would stall back-to-back reads. Writes of all ones at the top address and alternating patterns expose lane swaps and any nonzero upper byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WSTRB,
    ST_WHOLD,
    ST_RSTRB
  } ctrl_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int unsigned DATA_W = 40,
  parameter int unsigned DEV_W  = 16,
  parameter int unsigned N_DEV  = 3,
  localparam int unsigned BUS_W = DEV_W * N_DEV
) (
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BUS_W-1:0]  bus_o,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BUS_W-1:0] padded;
  assign padded = BUS_W'(wdata_i);

  for (genvar d = 0; d < N_DEV; d++) begin : g_lane
    assign bus_o[d*DEV_W +: DEV_W] = padded[d*DEV_W +: DEV_W];
  end

  assign rdata_o = bus_i[DATA_W-1:0];

  if (BUS_W > DATA_W) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^bus_i[BUS_W-1:DATA_W];
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 40,
  parameter int unsigned DEV_W  = 16,
  parameter int unsigned N_DEV  = 3,
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_WP   = 6,
  parameter int unsigned T_DH   = 2,
  parameter int unsigned T_RD   = 7,
  parameter int unsigned T_WR   = 2,
  localparam int unsigned BUS_W = DEV_W * N_DEV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [BUS_W-1:0]  dq_o,
  output logic              dq_oe_o,
  input  logic [BUS_W-1:0]  dq_i
);
  localparam int unsigned MAX_A = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int unsigned MAX_B = (T_DH > T_RD) ? T_DH : T_RD;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_T = (MAX_C > T_WR) ? MAX_C : T_WR;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  ctrl_state_e state_q, state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_bus;
  logic              done_q;
  logic              ph_load, ph_zero, rec_load, rec_zero;
  logic [CNT_W-1:0]  ph_val;
  logic              accept, finish, capture;

  assign accept = (state_q == ST_IDLE) && rec_zero && req_i;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    rec_load = 1'b0;
    finish   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = CNT_W'(T_AS - 1);
      end
      ST_SETUP: if (ph_zero) begin
        ph_load = 1'b1;
        if (wr_q) begin
          state_d = ST_WSTRB;
          ph_val  = CNT_W'(T_WP - 1);
        end else begin
          state_d = ST_RSTRB;
          ph_val  = CNT_W'(T_RD - 1);
        end
      end
      ST_WSTRB: if (ph_zero) begin
        state_d = ST_WHOLD;
        ph_load = 1'b1;
        ph_val  = CNT_W'(T_DH - 1);
      end
      ST_WHOLD: if (ph_zero) begin
        state_d  = ST_IDLE;
        rec_load = 1'b1;
        finish   = 1'b1;
      end
      ST_RSTRB: if (ph_zero) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
        capture = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        wr_q    <= wr_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= rdata_bus;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .load_i(ph_load), .load_val_i(ph_val), .zero_o(ph_zero)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_recov (
    .clk_i, .rst_ni, .load_i(rec_load), .load_val_i(CNT_W'(T_WR)), .zero_o(rec_zero)
  );

  sram_lane_map #(.DATA_W(DATA_W), .DEV_W(DEV_W), .N_DEV(N_DEV)) u_lanes (
    .wdata_i(wdata_q), .bus_o(dq_o), .bus_i(dq_i), .rdata_o(rdata_bus)
  );

  assign addr_o  = addr_q;
  assign ce_n_o  = !((state_q == ST_WSTRB) || (state_q == ST_RSTRB));
  assign we_n_o  = !(state_q == ST_WSTRB);
  assign oe_n_o  = !(state_q == ST_RSTRB);
  assign dq_oe_o = (state_q == ST_WSTRB) || (state_q == ST_WHOLD);
  assign busy_o  = (state_q != ST_IDLE) || !rec_zero;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned T_WP   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ce_n_o,
  input logic              we_n_o,
  input logic              oe_n_o,
  input logic              dq_oe_o
);
  logic [15:0] wp_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wp_cnt <= '0;
    else if (we_n_o)  wp_cnt <= '0;
    else              wp_cnt <= wp_cnt + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_n_o && we_n_o && oe_n_o && !dq_oe_o));

  assert_no_oe_in_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (oe_n_o && !ce_n_o));

  assert_write_pulse_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (wp_cnt == 16'(T_WP)));

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_o));

  assert_bus_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_n_o);

  assert_bus_during_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> dq_oe_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .T_WP(T_WP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .addr_o(addr_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
  .dq_oe_o(dq_oe_o)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;
  localparam int T_AS = 2, T_WP = 4, T_DH = 1, T_RD = 5, T_WR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [39:0] wdata = '0, rdata;
  logic done, busy, ce_n, we_n, oe_n, dq_oe;
  logic [15:0] addr_o;
  logic [47:0] dq_o, dq_i;

  always #4 clk = ~clk;

  sram_cycle_ctrl #(.T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_RD(T_RD), .T_WR(T_WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .addr_o(addr_o), .ce_n_o(ce_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req_tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // memory model: poison until access count met, upper byte junk
  logic [47:0] mem [int];
  logic [47:0] mem_rd;
  int acc;
  always @(posedge clk) begin
    if (!ce_n && !we_n) mem[int'(addr_o)] = dq_o;
  end
  always @(posedge clk) begin
    acc    <= (!ce_n && !oe_n && we_n) ? acc + 1 : 0;
    mem_rd <= mem.exists(int'(addr_o)) ? mem[int'(addr_o)] : 48'h0;
  end
  assign dq_i = (!ce_n && !oe_n && we_n && acc >= T_RD - 1) ?
                {8'hA5, mem_rd[39:0]} : 48'hBAD0_BAD0_BAD0;

  typedef struct { bit is_wr; logic [39:0] data; } exp_t;
  exp_t q[$];
  logic [39:0] shadow [int];
  logic [39:0] cur_wdata;

  task automatic issue(bit w, logic [15:0] a, logic [39:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    if (w) begin
      cur_wdata = d;
      shadow[int'(a)] = d;
      q.push_back('{1'b1, d});
    end else begin
      q.push_back('{1'b0, shadow.exists(int'(a)) ? shadow[int'(a)] : 40'h0});
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor / scoreboard
  int wp_run = 0, rd_run = 0, rec_run = 0;
  bit rec_track = 0, prev_ce_n = 1, prev_done = 0, prev_we_n = 1, prev_rd = 0;
  logic [15:0] prev_addr = '0;
  always @(negedge clk) if (rst_n && !finished) begin
    automatic bit rd_act = !ce_n && !oe_n;
    if (!we_n) begin
      check(oe_n == 1'b1, "R3", oe_n, 1);
      check(dq_oe && dq_o == {8'h00, cur_wdata}, "R8", dq_o, {8'h00, cur_wdata});
      wp_run++;
    end else if (!prev_we_n) begin
      check(wp_run == T_WP, "R3", wp_run, T_WP);
      check(dq_oe == (T_DH > 0), "R5", dq_oe, 1);
      wp_run = 0;
    end
    if (rd_act) begin
      rd_run++;
      check(we_n && !dq_oe, "R5", dq_oe, 0);
    end else if (prev_rd) begin
      check(rd_run == T_RD, "R2", rd_run, T_RD);
      rd_run = 0;
    end
    if (!ce_n) check(addr_o == prev_addr, "R4", addr_o, prev_addr);
    if (!busy) check(ce_n && we_n && oe_n && !dq_oe, "R5", dq_oe, 0);
    if (prev_done) check(!done, "R9", done, 0);
    if (rec_track) begin
      if (busy) rec_run++;
      else begin
        check(rec_run == T_WR, "R6", rec_run, T_WR);
        rec_track = 0;
      end
    end
    if (done) begin
      if (q.size() == 0) check(0, "R7", 1, 0);
      else begin
        automatic exp_t e = q.pop_front();
        if (e.is_wr) begin
          rec_track = 1; rec_run = 1;
          check(busy, "R6", busy, 1);
        end else begin
          check(rdata == e.data, "R2", rdata, e.data);
          check(!busy, "R9", busy, 0);
        end
      end
    end
    prev_we_n = we_n; prev_rd = rd_act; prev_ce_n = ce_n;
    prev_addr = addr_o; prev_done = done;
  end

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n && we_n && oe_n && !dq_oe && !busy && !done, "R1",
          {ce_n, we_n, oe_n, dq_oe, busy, done}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !busy, "R1",
          {ce_n, we_n, oe_n, dq_oe, busy}, 5'b11100);

    issue(1, 16'h0010, 40'h12_3456_789A);
    issue(0, 16'h0010, '0);
    issue(1, 16'hFFFF, 40'hFF_FFFF_FFFF);   // R8 top address, all ones
    issue(1, 16'h0000, 40'hAA_5555_AAAA);
    issue(0, 16'hFFFF, '0);
    issue(0, 16'h0000, '0);                 // R9 back-to-back reads
    issue(0, 16'h0010, '0);
    issue(0, 16'h1234, '0);                 // never written: zero

    // R7: request during busy is ignored
    issue(1, 16'h0020, 40'h01_0203_0405);
    check(busy, "R7", busy, 1);
    req = 1'b1; wr = 1'b1; addr = 16'h0020; wdata = 40'hEE_EEEE_EEEE;
    repeat (2) @(negedge clk);
    req = 1'b0;
    issue(0, 16'h0020, '0);

    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R7", q.size(), 0);
    finish_run();
  end
endmodule